// File: doc/BRIEF.md
# Interleaved Row/Column Parity Storage Array

This block is a small word-addressed store, held in flip-flops, that protects its contents with parity along rows and down columns instead of a per-word error-correcting code. Each data bit belongs to one of four interleaved parity groups: bit `i` of row `r` belongs to group `(i + r) mod 4`. Every word stores one row-parity bit per group. Every group keeps a column-parity vector as wide as a word, formed over the rows in which a column's bit falls into that group. A cluster of up to four neighbouring upsets, whether along a row or down a column, therefore leaves at most one bad bit per group, and each group can repair its own bit.

A client uses a single synchronous port. A write costs one extra cycle, during which the old word is read and the change is folded into the column parity. A read whose row parity checks clean returns data on the next cycle. A read whose row parity fails starts a recovery pass. The pass visits every row in order, one row per cycle, and gathers the column bits that the failing groups share with the bad row. It then rebuilds the bad bits from the column parity, stores the repaired word and returns it with a `corrected` flag. If another row that shares those columns also shows a failing group in common with the bad row, the pass returns the stored word untouched and raises `uncorrectable`. A test-only port flips chosen stored bits without touching any parity, so that upsets can be injected.

Top module: `hvp_array`

## Requirements
- R1: After reset, `busy_o`, `rvalid_o`, `corrected_o` and `uncorrectable_o` are low, and every row reads back as zero with clean status.
- R2: A write accepted while idle raises `busy_o` for exactly one cycle. A later read of that row returns the written word.
- R3: A read of a row whose row parity checks clean raises `rvalid_o` with the stored word in the cycle after acceptance. `busy_o`, `corrected_o` and `uncorrectable_o` stay low.
- R4: A request presented only while `busy_o` is high is ignored: the storage it targets keeps its contents and no read result is produced for it.
- R5: Bit `i` of row `r` is in parity group `(i + r) mod 4`. A single flipped bit in a row is repaired on read: `rvalid_o` and `corrected_o` are high together with the original word, in the first cycle `busy_o` is low again. The repaired word is written back, so the next read of that row is clean.
- R6: A read that finds a row-parity failure keeps `busy_o` high for exactly DEPTH+1 cycles: DEPTH sweep cycles plus one repair cycle.
- R7: Up to four adjacent flipped bits within one row fall into distinct groups and are all repaired in a single recovery pass.
- R8: The same bit column flipped in two consecutive rows is repaired by two independent reads, one per row.
- R9: If the failing row and another row of the same `r mod 4` class both fail a common group, the result carries `uncorrectable_o` and `rvalid_o` with the stored, unrepaired word. `corrected_o` stays low and the storage is left unchanged, so a repeated read reports the same.
- R10: A bit flip injected in the same cycle that a read of the same row is accepted takes effect after that read. The read returns the pre-flip word with clean status, and the next read repairs the flip.
- R11: Column parity follows every write, so after rows are overwritten, single flips in the new contents are still repaired to the newly written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, taken only while `busy_o` is low |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Row address |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data |
| rvalid_o | output | 1 | Read data valid, one-cycle pulse |
| busy_o | output | 1 | Write update or recovery in progress |
| corrected_o | output | 1 | Returned word was repaired |
| uncorrectable_o | output | 1 | Failure could not be repaired; data returned as stored |
| inj_en_i | input | 1 | Test-only: flip stored bits this cycle |
| inj_row_i | input | AW | Test-only: row to flip |
| inj_mask_i | input | WIDTH | Test-only: bits to flip |

## Verification
The test-only flip port and the read path can act on the same row in the same cycle. The bench provokes this by asserting the read request and a one-bit flip of that row on the same clock edge. It expects the scoreboard to receive the original word with clean status from that read, and a repaired word with `corrected_o` from the read that follows. A second overlap is a request held during the busy cycle of a write. The bench judges it by reading the targeted row afterwards and finding its earlier contents.

// File: rtl/hvp_pkg.sv
package hvp_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WUPD  = 2'd1,
        S_SWEEP = 2'd2,
        S_FIX   = 2'd3
    } state_e;

    // Parity group of a bit: neighbours along a row and down a column differ.
    function automatic int group_of(input int bit_idx, input int row, input int ngrp);
        return (bit_idx + row) % ngrp;
    endfunction

endpackage

// File: rtl/hvp_hpar_gen.sv
module hvp_hpar_gen #(
    parameter int WIDTH = 16,
    parameter int NDOM  = 4,
    parameter int AW    = 3
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic [AW-1:0]    row_i,
    output logic [NDOM-1:0]  par_o
);
    always_comb begin
        par_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            for (int d = 0; d < NDOM; d++) begin
                if (hvp_pkg::group_of(i, int'(row_i), NDOM) == d) begin
                    par_o[d] = par_o[d] ^ word_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/hvp_rebuild.sv
module hvp_rebuild #(
    parameter int WIDTH = 16,
    parameter int NDOM  = 4,
    parameter int AW    = 3
) (
    input  logic [WIDTH-1:0]           word_i,
    input  logic [AW-1:0]              row_i,
    input  logic [NDOM-1:0]            mask_i,
    input  logic [WIDTH-1:0]           acc_i,
    input  logic [NDOM-1:0][WIDTH-1:0] vpar_i,
    output logic [WIDTH-1:0]           fixed_o
);
    always_comb begin
        fixed_o = word_i;
        for (int i = 0; i < WIDTH; i++) begin
            for (int d = 0; d < NDOM; d++) begin
                if (hvp_pkg::group_of(i, int'(row_i), NDOM) == d && mask_i[d]) begin
                    fixed_o[i] = acc_i[i] ^ vpar_i[d][i];
                end
            end
        end
    end
endmodule

// File: rtl/hvp_array.sv
module hvp_array #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    parameter int NDOM  = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     req_i,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] addr_i,
    input  logic [WIDTH-1:0]         wdata_i,
    output logic [WIDTH-1:0]         rdata_o,
    output logic                     rvalid_o,
    output logic                     busy_o,
    output logic                     corrected_o,
    output logic                     uncorrectable_o,
    input  logic                     inj_en_i,
    input  logic [$clog2(DEPTH)-1:0] inj_row_i,
    input  logic [WIDTH-1:0]         inj_mask_i
);
    import hvp_pkg::*;

    localparam int AW    = $clog2(DEPTH);
    localparam int NGEN  = 3;
    localparam int G_RD  = 0;
    localparam int G_WR  = 1;
    localparam int G_SW  = 2;
    localparam logic [AW-1:0] LAST_ROW = AW'(DEPTH - 1);

    typedef struct packed {
        state_e                         st;
        logic [DEPTH-1:0][WIDTH-1:0]    mem;
        logic [DEPTH-1:0][NDOM-1:0]     hpar;
        logic [NDOM-1:0][WIDTH-1:0]     vpar;
        logic [AW-1:0]                  row;
        logic [AW-1:0]                  cnt;
        logic [WIDTH-1:0]               wdata;
        logic [WIDTH-1:0]               acc;
        logic [NDOM-1:0]                mask;
        logic                           clash;
        logic [WIDTH-1:0]               rdata;
        logic                           rvalid;
        logic                           corr;
        logic                           unc;
    } state_t;

    state_t q, n;

    logic [NGEN-1:0][WIDTH-1:0] gen_word;
    logic [NGEN-1:0][AW-1:0]    gen_row;
    logic [NGEN-1:0][NDOM-1:0]  gen_par;
    logic [WIDTH-1:0]           fixed_word;

    always_comb begin
        gen_word[G_RD] = q.mem[addr_i];
        gen_row[G_RD]  = addr_i;
        gen_word[G_WR] = q.wdata;
        gen_row[G_WR]  = q.row;
        gen_word[G_SW] = q.mem[q.cnt];
        gen_row[G_SW]  = q.cnt;
    end

    for (genvar g = 0; g < NGEN; g++) begin : g_hpar
        hvp_hpar_gen #(.WIDTH(WIDTH), .NDOM(NDOM), .AW(AW)) u_gen (
            .word_i (gen_word[g]),
            .row_i  (gen_row[g]),
            .par_o  (gen_par[g])
        );
    end

    hvp_rebuild #(.WIDTH(WIDTH), .NDOM(NDOM), .AW(AW)) u_rebuild (
        .word_i  (q.mem[q.row]),
        .row_i   (q.row),
        .mask_i  (q.mask),
        .acc_i   (q.acc),
        .vpar_i  (q.vpar),
        .fixed_o (fixed_word)
    );

    logic [NDOM-1:0] rd_mism;
    logic [NDOM-1:0] sw_mism;
    logic [WIDTH-1:0] wr_diff;
    logic             same_class;

    always_comb begin
        rd_mism    = gen_par[G_RD] ^ q.hpar[addr_i];
        sw_mism    = gen_par[G_SW] ^ q.hpar[q.cnt];
        wr_diff    = q.mem[q.row] ^ q.wdata;
        same_class = (q.cnt != q.row) &&
                     ((int'(q.cnt) % NDOM) == (int'(q.row) % NDOM));

        n        = q;
        n.rvalid = 1'b0;
        n.corr   = 1'b0;
        n.unc    = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (req_i) begin
                    n.row = addr_i;
                    if (we_i) begin
                        n.wdata = wdata_i;
                        n.st    = S_WUPD;
                    end else if (rd_mism == '0) begin
                        n.rdata  = q.mem[addr_i];
                        n.rvalid = 1'b1;
                    end else begin
                        n.mask  = rd_mism;
                        n.cnt   = '0;
                        n.acc   = '0;
                        n.clash = 1'b0;
                        n.st    = S_SWEEP;
                    end
                end
            end
            S_WUPD: begin
                for (int i = 0; i < WIDTH; i++) begin
                    for (int d = 0; d < NDOM; d++) begin
                        if (group_of(i, int'(q.row), NDOM) == d) begin
                            n.vpar[d][i] = q.vpar[d][i] ^ wr_diff[i];
                        end
                    end
                end
                n.mem[q.row]  = q.wdata;
                n.hpar[q.row] = gen_par[G_WR];
                n.st          = S_IDLE;
            end
            S_SWEEP: begin
                if (same_class) begin
                    n.acc = q.acc ^ q.mem[q.cnt];
                    if ((sw_mism & q.mask) != '0) begin
                        n.clash = 1'b1;
                    end
                end
                n.cnt = q.cnt + 1'b1;
                if (q.cnt == LAST_ROW) begin
                    n.st = S_FIX;
                end
            end
            S_FIX: begin
                n.rvalid = 1'b1;
                if (q.clash) begin
                    n.rdata = q.mem[q.row];
                    n.unc   = 1'b1;
                end else begin
                    n.mem[q.row] = fixed_word;
                    n.rdata      = fixed_word;
                    n.corr       = 1'b1;
                end
                n.st = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase

        // test-only upset, applied after any normal update of the same cycle
        if (inj_en_i) begin
            n.mem[inj_row_i] = n.mem[inj_row_i] ^ inj_mask_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign rdata_o         = q.rdata;
    assign rvalid_o        = q.rvalid;
    assign busy_o          = (q.st != S_IDLE);
    assign corrected_o     = q.corr;
    assign uncorrectable_o = q.unc;

endmodule

// File: rtl/hvp_array_chk.sv
module hvp_array_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic req_i,
    input logic we_i,
    input logic rvalid_o,
    input logic busy_o,
    input logic corrected_o,
    input logic uncorrectable_o
);
    p_write_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && !busy_o) |=> busy_o ##1 !busy_o);

    p_read_answer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i && !busy_o) |=> (rvalid_o ^ busy_o));

    p_no_result_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !rvalid_o);

    p_status_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (corrected_o || uncorrectable_o) |-> (rvalid_o && !busy_o && $past(busy_o)));

    p_status_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({corrected_o, uncorrectable_o}));
endmodule

bind hvp_array hvp_array_chk u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_i           (req_i),
    .we_i            (we_i),
    .rvalid_o        (rvalid_o),
    .busy_o          (busy_o),
    .corrected_o     (corrected_o),
    .uncorrectable_o (uncorrectable_o)
);

// File: tb/hvp_array_bench.sv
module hvp_array_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int D  = 8;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, we = 1'b0, inj_en = 1'b0;
    logic [AW-1:0] addr = '0, inj_row = '0;
    logic [W-1:0]  wdata = '0, inj_mask = '0;
    logic [W-1:0]  rdata;
    logic          rvalid, busy, corr, unc;

    always #(CLK_PERIOD/2) clk = ~clk;

    hvp_array #(.WIDTH(W), .DEPTH(D), .NDOM(4)) u_hvp_array (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .busy_o(busy),
        .corrected_o(corr), .uncorrectable_o(unc), .inj_en_i(inj_en),
        .inj_row_i(inj_row), .inj_mask_i(inj_mask)
    );

    typedef struct {
        logic [W-1:0] data;
        logic         c;
        logic         u;
        string        tag;
    } item_t;

    item_t        sb[$];
    logic [W-1:0] model [D];
    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: compares every returned word against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (sb.size() == 0) begin
                chk(0, "R4", "unexpected rvalid", 1, 0);
            end else begin
                item_t e;
                e = sb.pop_front();
                chk(rdata == e.data, e.tag, "rdata", rdata, e.data);
                chk(corr == e.c, e.tag, "corrected", corr, e.c);
                chk(unc == e.u, e.tag, "uncorrectable", unc, e.u);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_write(input int row, input logic [W-1:0] d);
        logic b1;
        wait_idle();
        req = 1; we = 1; addr = AW'(row); wdata = d;
        @(negedge clk);
        req = 0; we = 0;
        model[row] = d;
        b1 = busy;
        @(negedge clk);
        chk(b1 && !busy, "R2", "write busy one cycle", {b1, busy}, 2'b10);
    endtask

    task automatic do_read(input int row, input logic [W-1:0] d, input logic c,
                           input logic u, input string tag, output int bcyc);
        item_t e;
        wait_idle();
        e.data = d; e.c = c; e.u = u; e.tag = tag;
        sb.push_back(e);
        req = 1; we = 0; addr = AW'(row);
        @(negedge clk);
        req = 0;
        bcyc = 0;
        if (!c && !u) chk(rvalid && !busy, "R3", "clean read next cycle", {rvalid, busy}, 2'b10);
        while (busy) begin
            bcyc++;
            @(negedge clk);
        end
    endtask

    task automatic inject(input int row, input logic [W-1:0] m);
        wait_idle();
        inj_en = 1; inj_row = AW'(row); inj_mask = m;
        @(negedge clk);
        inj_en = 0;
    endtask

    function automatic logic [W-1:0] pat(input int r, input logic [W-1:0] seed);
        return seed ^ W'(r * 16'h1357) ^ W'(r << 9);
    endfunction

    initial begin
        int bc;
        repeat (3) @(negedge clk);
        chk(!busy && !rvalid && !corr && !unc, "R1", "outputs in reset",
            {busy, rvalid, corr, unc}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !rvalid, "R1", "idle after reset", {busy, rvalid}, 0);
        for (int r = 0; r < D; r++) model[r] = '0;
        do_read(5, '0, 0, 0, "R1", bc);
        do_read(0, '0, 0, 0, "R1", bc);

        // R2 / R3: fill and read back
        for (int r = 0; r < D; r++) do_write(r, pat(r, 16'hA5C3));
        for (int r = 0; r < D; r++) do_read(r, model[r], 0, 0, "R3", bc);

        // R4: request held only during the busy cycle of a write is ignored
        wait_idle();
        req = 1; we = 1; addr = 1; wdata = 16'h1234;
        @(negedge clk);
        model[1] = 16'h1234;
        addr = 3; wdata = 16'hDEAD;
        @(negedge clk);
        req = 0; we = 0;
        do_read(3, model[3], 0, 0, "R4", bc);
        do_read(1, model[1], 0, 0, "R4", bc);

        // R5 / R6: single flip
        inject(2, 16'h0020);
        do_read(2, model[2], 1, 0, "R5", bc);
        chk(bc == D + 1, "R6", "recovery busy cycles", bc, D + 1);
        do_read(2, model[2], 0, 0, "R5", bc);

        // R7: four adjacent bits in one row
        inject(3, 16'h03C0);
        do_read(3, model[3], 1, 0, "R7", bc);
        chk(bc == D + 1, "R6", "burst busy cycles", bc, D + 1);
        do_read(3, model[3], 0, 0, "R7", bc);

        // R8: same column, consecutive rows
        inject(4, 16'h0200);
        inject(5, 16'h0200);
        do_read(4, model[4], 1, 0, "R8", bc);
        do_read(5, model[5], 1, 0, "R8", bc);
        do_read(4, model[4], 0, 0, "R8", bc);

        // R9: same column in rows 6 and 2 (same class, same group)
        inject(6, 16'h0002);
        inject(2, 16'h0002);
        do_read(6, model[6] ^ 16'h0002, 0, 1, "R9", bc);
        do_read(6, model[6] ^ 16'h0002, 0, 1, "R9", bc);
        inject(6, 16'h0002);
        inject(2, 16'h0002);
        do_read(2, model[2], 0, 0, "R9", bc);
        do_read(6, model[6], 0, 0, "R9", bc);

        // R10: flip injected on the same edge as a read of that row
        wait_idle();
        begin
            item_t e;
            e.data = model[7]; e.c = 0; e.u = 0; e.tag = "R10";
            sb.push_back(e);
        end
        req = 1; we = 0; addr = 7;
        inj_en = 1; inj_row = 7; inj_mask = 16'h0001;
        @(negedge clk);
        req = 0; inj_en = 0;
        chk(rvalid && !corr, "R10", "pre-flip read clean", {rvalid, corr}, 2'b10);
        do_read(7, model[7], 1, 0, "R10", bc);

        // R11: overwrite, then flips in new contents
        for (int r = 0; r < D; r++) do_write(r, pat(r, 16'h3C96));
        inject(0, 16'h0001);
        inject(1, 16'h4000);
        do_read(0, model[0], 1, 0, "R11", bc);
        do_read(1, model[1], 1, 0, "R11", bc);
        do_read(0, model[0], 0, 0, "R11", bc);

        wait_idle();
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule